// File: doc/BRIEF.md
# GPIO Port Interrupt Status Unit

This block turns the pins of one general-purpose input port into interrupt requests. Every pin has its own choice of detection: level sensitive (active high or active low) or edge triggered (rising or falling). The selection uses a mode bit and a polarity bit per pin. The pins first cross into the clock domain through a two-flop synchronizer. Each pin can then be passed through a debouncer that accepts a new level only once it has stayed put for a set number of sample ticks.

The unit keeps a raw status vector that records, per pin, whether an interrupt condition is present, and that vector does not depend on the enable mask. AND-ing the raw vector with the enable mask gives the masked status. The single interrupt output is high whenever any masked bit is set. Latched edge events stay set until software writes a one to the matching bit of the end-of-interrupt register. That register reads back as zero and has no effect on level-sensitive pins. All registers sit behind a small register port with a separate write side and a combinational read side.

Top module: `gpio_irq_unit`

## Requirements
- R1: A pin with mode bit 0 (level) and polarity bit 1 has a raw status bit equal to its synchronized (or debounced) pin value.
- R2: A pin with mode bit 0 (level) and polarity bit 0 has a raw status bit equal to the inverse of its pin value. The bit clears by itself when the pin leaves its asserting level.
- R3: A pin with mode bit 1 (edge) sets its raw bit on a rising transition when polarity is 1, or on a falling transition when polarity is 0. The bit stays set after the pin returns.
- R4: Writing the end-of-interrupt register (address 3) clears each edge-mode raw bit whose data bit is 1. Bits written 0 and level-mode pins are unaffected, and address 3 reads as zero.
- R5: When an end-of-interrupt write lands in the same cycle as a new qualifying edge on that pin, the raw bit remains set.
- R6: Changing the enable mask (address 2) never changes the raw status (address 5).
- R7: Masked status (address 6) equals raw AND enable. `irq_out` is high exactly when any masked bit is set.
- R8: With the debounce enable bit set (address 4), a pin pulse shorter than DB_TICKS sample ticks is ignored. A level held stable for longer is accepted and detected. Without debounce, the same short pulse is detected.
- R9: A pin change driven between clock edges shows up in level raw status after exactly two rising clock edges, and not after one.
- R10: After reset, mode (address 0) reads 0, polarity (address 1) reads all ones, enable and debounce read 0, and raw and masked read 0 with the pins low. Writes to the raw and masked addresses are ignored. Read data bits above NPINS-1 and address 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pins_in | input | NPINS | Asynchronous port pin levels |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | NPINS | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | DW | Register read data, upper bits zero |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the unit with eight pins, a 32-bit read bus, a sample-tick divider of 2 and a stability count of 4. A qualifying debounce run therefore takes about eight clock cycles. This makes it cheap both to show a two-cycle glitch being rejected on a debounced pin while a neighbouring pin without debounce latches it, and to show a held level being accepted. The 32-bit read width exposes the reserved upper bits, and the eight pins let mixed mode and polarity patterns cover all four detection kinds in one vector.

// File: rtl/gpio_irq_pkg.sv
// Package: register addresses shared by the interrupt status unit.
// Assumes a 3-bit register address space.
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        REG_MODE  = 3'd0,
        REG_POL   = 3'd1,
        REG_EN    = 3'd2,
        REG_EOI   = 3'd3,
        REG_DBEN  = 3'd4,
        REG_RAW   = 3'd5,
        REG_MSK   = 3'd6,
        REG_SPARE = 3'd7
    } gpio_reg_e;

endpackage

// File: rtl/gpio_pin_sync.sv
// Two-flop synchronizer for a vector of asynchronous pins.
// Assumes each pin is an independent single-bit signal (no bus coherency needed).
module gpio_pin_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    // Two register stages to settle metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= async_in;
            stab_q <= meta_q;
        end
    end

    assign sync_out = stab_q;

endmodule

// File: rtl/gpio_debounce.sv
// Per-pin debouncer. A shared divider produces a sample tick every DB_DIV
// cycles. A pin's filtered level moves to the input level only after the
// input has differed from it on DB_TICKS consecutive ticks.
// Assumes synchronized inputs.
module gpio_debounce #(
    parameter int W        = 8,
    parameter int DB_DIV   = 16,
    parameter int DB_TICKS = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int DIVW = (DB_DIV   > 1) ? $clog2(DB_DIV)   : 1;
    localparam int CNTW = (DB_TICKS > 1) ? $clog2(DB_TICKS) : 1;

    logic tick;

    generate
        if (DB_DIV > 1) begin : g_div
            logic [DIVW-1:0] div_q;
            assign tick = (div_q == DIVW'(DB_DIV - 1));
            // Free-running sample divider.
            always_ff @(posedge clk) begin
                if (!rst_n) div_q <= '0;
                else if (tick) div_q <= '0;
                else div_q <= div_q + 1'b1;
            end
        end else begin : g_nodiv
            assign tick = 1'b1;
        end
    endgenerate

    generate
        for (genvar g = 0; g < W; g++) begin : g_pin
            logic [CNTW-1:0] run_q;
            logic            lvl_q;
            // Count consecutive differing samples; adopt the new level at the limit.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    run_q <= '0;
                    lvl_q <= 1'b0;
                end else if (tick) begin
                    if (din[g] == lvl_q) begin
                        run_q <= '0;
                    end else if (run_q == CNTW'(DB_TICKS - 1)) begin
                        lvl_q <= din[g];
                        run_q <= '0;
                    end else begin
                        run_q <= run_q + 1'b1;
                    end
                end
            end
            assign dout[g] = lvl_q;
        end
    endgenerate

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin interrupt condition detector. Level mode reports the pin compared
// with its polarity. Edge mode latches the selected transition until a clear
// strobe arrives, and a new edge wins over a clear in the same cycle.
// Assumes pin_lvl is already synchronous to clk.
module gpio_irq_detect #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_lvl,
    input  logic [W-1:0] edge_mode,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] clr,
    output logic [W-1:0] hit,
    output logic [W-1:0] raw
);

    logic [W-1:0] prev_q;
    logic [W-1:0] latch_q;

    generate
        for (genvar g = 0; g < W; g++) begin : g_bit
            // Selected transition: rising for polarity 1, falling for polarity 0.
            assign hit[g] = pol[g] ? (pin_lvl[g] & ~prev_q[g])
                                   : (~pin_lvl[g] & prev_q[g]);
            // Raw condition: latched event in edge mode, polarity-matched level otherwise.
            assign raw[g] = edge_mode[g] ? latch_q[g] : ~(pin_lvl[g] ^ pol[g]);
        end
    endgenerate

    // Previous level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= pin_lvl;
    end

    // Edge latch: set by a hit, cleared by a strobe, held clear in level mode.
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= '0;
        else latch_q <= edge_mode & (hit | (latch_q & ~clr));
    end

endmodule

// File: rtl/gpio_irq_unit.sv
// Top of the port interrupt status unit: configuration registers, pin
// synchronizer, optional debounce per pin, detector and read multiplexer.
// Assumes DW >= NPINS and a single write per cycle.
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int NPINS    = 8,
    parameter int DW       = 32,
    parameter int DB_DIV   = 16,
    parameter int DB_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [NPINS-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             irq_out
);

    logic [NPINS-1:0] mode_q;
    logic [NPINS-1:0] pol_q;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] dben_q;
    logic [NPINS-1:0] eoi;
    logic [NPINS-1:0] sync_pins;
    logic [NPINS-1:0] db_pins;
    logic [NPINS-1:0] eff_pins;
    logic [NPINS-1:0] hit;
    logic [NPINS-1:0] raw;
    logic [NPINS-1:0] masked;
    logic [NPINS-1:0] rd_sel;

    // Configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            pol_q  <= '1;
            en_q   <= '0;
            dben_q <= '0;
        end else if (wr_en) begin
            case (gpio_reg_e'(wr_addr))
                REG_MODE: mode_q <= wr_data;
                REG_POL:  pol_q  <= wr_data;
                REG_EN:   en_q   <= wr_data;
                REG_DBEN: dben_q <= wr_data;
                default:  ;
            endcase
        end
    end

    // End-of-interrupt strobe lasts only for the write cycle.
    assign eoi = (wr_en && (gpio_reg_e'(wr_addr) == REG_EOI)) ? wr_data : '0;

    gpio_pin_sync #(.W(NPINS)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins_in),
        .sync_out (sync_pins)
    );

    gpio_debounce #(.W(NPINS), .DB_DIV(DB_DIV), .DB_TICKS(DB_TICKS)) db_i (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_pins),
        .dout  (db_pins)
    );

    // Per-pin choice between filtered and plain synchronized level.
    assign eff_pins = (dben_q & db_pins) | (~dben_q & sync_pins);

    gpio_irq_detect #(.W(NPINS)) det_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_lvl   (eff_pins),
        .edge_mode (mode_q),
        .pol       (pol_q),
        .clr       (eoi),
        .hit       (hit),
        .raw       (raw)
    );

    assign masked  = raw & en_q;
    assign irq_out = |masked;

    // Register read selection.
    always_comb begin
        case (gpio_reg_e'(rd_addr))
            REG_MODE: rd_sel = mode_q;
            REG_POL:  rd_sel = pol_q;
            REG_EN:   rd_sel = en_q;
            REG_DBEN: rd_sel = dben_q;
            REG_RAW:  rd_sel = raw;
            REG_MSK:  rd_sel = masked;
            default:  rd_sel = '0;
        endcase
    end

    assign rd_data = DW'(rd_sel);

endmodule

// File: rtl/gpio_irq_chk.sv
// Property checker for the interrupt status unit, attached with bind.
// Assumes the unit's internal names mode_q, pol_q, en_q, eoi, eff_pins, hit, raw, masked.
module gpio_irq_chk #(
    parameter int NPINS = 8,
    parameter int DW    = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] edge_mode,
    input logic [NPINS-1:0] pol,
    input logic [NPINS-1:0] en,
    input logic [NPINS-1:0] eoi,
    input logic [NPINS-1:0] eff,
    input logic [NPINS-1:0] hit,
    input logic [NPINS-1:0] raw,
    input logic [NPINS-1:0] masked,
    input logic             irq,
    input logic [DW-1:0]    rd_data
);

    logic             live_q;
    logic [NPINS-1:0] hold_v;
    logic [NPINS-1:0] new_v;

    // Marks cycles whose previous cycle was out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else live_q <= 1'b1;
    end

    assign hold_v = edge_mode & raw & ~eoi;
    assign new_v  = edge_mode & hit;

    AST_LVL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~edge_mode & pol) == (eff & ~edge_mode & pol)); // R1

    AST_LVL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (raw & ~edge_mode & ~pol) == (~eff & ~edge_mode & ~pol)); // R2

    AST_EDGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((raw & edge_mode & $past(hold_v)) == (edge_mode & $past(hold_v)))); // R3

    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> ((raw & edge_mode & $past(new_v)) == (edge_mode & $past(new_v)))); // R5

    AST_IRQ_ANY: assert property (@(posedge clk) disable iff (!rst_n)
        (masked != '0) |-> irq); // R7

    AST_IRQ_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((raw & en) != '0)); // R7

    generate
        if (DW > NPINS) begin : g_rsvd
            AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
                rd_data[DW-1:NPINS] == '0); // R10
        end
    endgenerate

endmodule

bind gpio_irq_unit gpio_irq_chk #(.NPINS(NPINS), .DW(DW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .edge_mode (mode_q),
    .pol       (pol_q),
    .en        (en_q),
    .eoi       (eoi),
    .eff       (eff_pins),
    .hit       (hit),
    .raw       (raw),
    .masked    (masked),
    .irq       (irq_out),
    .rd_data   (rd_data)
);

// File: tb/gpio_irq_unit_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_unit_tb_top;

    localparam int NPINS = 8;
    localparam int DW    = 32;

    localparam logic [2:0] A_MODE = 3'd0;
    localparam logic [2:0] A_POL  = 3'd1;
    localparam logic [2:0] A_EN   = 3'd2;
    localparam logic [2:0] A_EOI  = 3'd3;
    localparam logic [2:0] A_DBEN = 3'd4;
    localparam logic [2:0] A_RAW  = 3'd5;
    localparam logic [2:0] A_MSK  = 3'd6;
    localparam logic [2:0] A_SPR  = 3'd7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NPINS-1:0] pins_in = '0;
    logic             wr_en = 1'b0;
    logic [2:0]       wr_addr = '0;
    logic [NPINS-1:0] wr_data = '0;
    logic [2:0]       rd_addr = '0;
    logic [DW-1:0]    rd_data;
    logic             irq_out;

    always #2 clk = ~clk;

    gpio_irq_unit #(.NPINS(NPINS), .DW(DW), .DB_DIV(2), .DB_TICKS(4)) dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_in (pins_in),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_out (irq_out)
    );

    typedef struct {
        bit          is_irq;
        logic [2:0]  addr;
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    int n_run  = 0;
    int n_fail = 0;
    int n_done = 0;
    int n_push = 0;
    bit finished = 1'b0;

    // Monitor: pop expected items and compare against the design.
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() != 0) begin
                item_t it;
                logic [31:0] got;
                it = q.pop_front();
                rd_addr = it.addr;
                #0.5;
                got = it.is_irq ? {31'b0, irq_out} : rd_data;
                n_run++;
                if (got !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
                end
                n_done++;
            end
        end
    end

    // Driver side: queue a check and wait until the monitor has made it.
    task automatic chk(input bit is_irq, input logic [2:0] addr,
                       input logic [31:0] exp, input string tag);
        item_t it;
        it.is_irq = is_irq;
        it.addr   = addr;
        it.exp    = exp;
        it.tag    = tag;
        q.push_back(it);
        n_push++;
        while (n_done < n_push) @(posedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [NPINS-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog all actual=timeout expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(2);

        // R10: reset state and reserved reads
        chk(0, A_MODE, 32'h00, "R10 mode reset");
        chk(0, A_POL,  32'hFF, "R10 pol reset");
        chk(0, A_EN,   32'h00, "R10 enable reset");
        chk(0, A_DBEN, 32'h00, "R10 debounce reset");
        chk(0, A_RAW,  32'h00, "R10 raw reset");
        chk(0, A_MSK,  32'h00, "R10 masked reset");
        chk(0, A_EOI,  32'h00, "R10 eoi reads zero");
        chk(0, A_SPR,  32'h00, "R10 spare reads zero");
        chk(1, A_RAW,  32'h0,  "R10 irq reset");

        // R9: two-edge synchronizer latency
        @(negedge clk);
        pins_in = 8'h01;
        chk(0, A_RAW, 32'h00, "R9 not after one edge");
        chk(0, A_RAW, 32'h01, "R9 visible after two edges");

        // R1: active-high level
        @(negedge clk);
        pins_in = 8'hA5;
        settle(4);
        chk(0, A_RAW, 32'hA5, "R1 level high follows pins");

        // R2: active-low level, self-clearing
        wr(A_POL, 8'h00);
        settle(2);
        chk(0, A_RAW, 32'h5A, "R2 level low inverts pins");
        pins_in = 8'h0F;
        settle(4);
        chk(0, A_RAW, 32'hF0, "R2 clears when pin leaves level");

        // R6 / R7: enable mask
        wr(A_EN, 8'h10);
        settle(1);
        chk(0, A_RAW, 32'hF0, "R6 raw unchanged by enable");
        chk(0, A_MSK, 32'h10, "R7 masked is raw and enable");
        chk(1, A_RAW, 32'h1,  "R7 irq high with masked bit");
        wr(A_EN, 8'h01);
        settle(1);
        chk(0, A_MSK, 32'h00, "R7 masked empty");
        chk(1, A_RAW, 32'h0,  "R7 irq low with no masked bit");
        chk(0, A_RAW, 32'hF0, "R6 raw still unchanged");
        wr(A_EN, 8'h00);

        // R3: edge detection in both directions
        @(negedge clk);
        pins_in = 8'h00;
        settle(4);
        wr(A_POL, 8'h0F);
        wr(A_MODE, 8'hFF);
        settle(2);
        chk(0, A_RAW, 32'h00, "R3 no event before edges");
        pins_in = 8'hFF;
        settle(5);
        chk(0, A_RAW, 32'h0F, "R3 rising edges latched");
        pins_in = 8'h00;
        settle(5);
        chk(0, A_RAW, 32'hFF, "R3 falling edges latched, rising held");

        // R4: end-of-interrupt clearing
        wr(A_EOI, 8'h03);
        settle(1);
        chk(0, A_RAW, 32'hFC, "R4 eoi clears selected edge bits");
        wr(A_MODE, 8'h0F);
        settle(2);
        chk(0, A_RAW, 32'hFC, "R4 level pins active low asserted");
        wr(A_EOI, 8'hF0);
        settle(1);
        chk(0, A_RAW, 32'hFC, "R4 eoi ignored on level pins");
        wr(A_RAW, 8'h00);
        wr(A_MSK, 8'hFF);
        settle(1);
        chk(0, A_RAW, 32'hFC, "R10 write to raw ignored");
        chk(0, A_MSK, 32'h00, "R10 write to masked ignored");

        // R5: clear and new edge in the same cycle
        wr(A_MODE, 8'hFF);
        wr(A_POL, 8'hFF);
        wr(A_EOI, 8'hFF);
        settle(2);
        chk(0, A_RAW, 32'h00, "R4 all edge bits cleared");
        @(negedge clk);
        pins_in = 8'h20;
        settle(5);
        chk(0, A_RAW, 32'h20, "R3 bit5 rising latched");
        @(negedge clk);
        pins_in = 8'h00;
        settle(5);
        @(negedge clk);
        pins_in = 8'h20;
        @(negedge clk);
        wr(A_EOI, 8'h20);
        settle(1);
        chk(0, A_RAW, 32'h20, "R5 edge wins over same-cycle eoi");
        wr(A_EOI, 8'h20);
        settle(1);
        chk(0, A_RAW, 32'h00, "R4 later eoi clears bit5");
        @(negedge clk);
        pins_in = 8'h00;
        settle(5);

        // R8: debounce on pin 3, none on pin 4
        wr(A_DBEN, 8'h08);
        wr(A_EOI, 8'hFF);
        settle(20);
        chk(0, A_RAW, 32'h00, "R8 clean start");
        @(negedge clk);
        pins_in = 8'h18;
        settle(2);
        pins_in = 8'h00;
        settle(30);
        chk(0, A_RAW, 32'h10, "R8 short pulse filtered on debounced pin");
        pins_in = 8'h08;
        settle(30);
        chk(0, A_RAW, 32'h18, "R8 stable level accepted");

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule